// File: doc/BRIEF.md
# Variable-Rate Stepper Phase Sequencer

This block drives the four coil lines of a two-phase stepper with a four-state, full-step pattern. A free-running divide-by-two prescaler produces a tick. The tick advances a 16-bit interval counter, and the counter is compared against an active period. Each match is a step event: the interval counter restarts from zero, a 2-bit phase index moves one position in the commanded direction, and the coil pattern for the new index appears on the output.

Software or a control loop sets the step rate by writing a period value through a single-cycle write port. The value is clamped into the legal range and held in a staging register with a pending flag. It moves into the active period only at the next step event, so the interval already running is never cut short or stretched. A one-cycle strobe marks every step, so a consumer can count steps and measure their spacing.

Top module: `stepper_phase_gen`

## Requirements
- R1: While reset is held and straight after it, pattern_o is 4'b0101 and step_o is low. The active period is 50, so the first step strobe comes 100 clock cycles after reset is released.
- R2: With active period P, successive step strobes are exactly 2*P clock cycles apart, because the interval counter advances once every two clocks.
- R3: pattern_o is decoded from the phase index as follows: 0 gives 4'b0101, 1 gives 4'b1001, 2 gives 4'b1010 and 3 gives 4'b0110.
- R4: At each step the phase index increments modulo 4 when dir_i is high and decrements modulo 4 when it is low. dir_i is sampled on the clock edge of the step.
- R5: step_o is high for exactly one cycle per step, and it is high in the same cycle in which the new pattern first appears.
- R6: A written period does not alter the interval in progress. The step that ends that interval loads it, and it governs the interval that follows.
- R7: A written value below 50 is stored as 50.
- R8: A written value above 50000 is stored as 50000.
- R9: A write in the same cycle as a step event is kept pending and loaded at the next step. A value that was already pending is loaded at the current step.
- R10: pattern_o changes only in the cycle in which step_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Step direction, 1 = forward |
| wr_en_i | input | 1 | Period write strobe |
| wr_data_i | input | 16 | Period value in prescaled ticks |
| pattern_o | output | 4 | Coil drive pattern |
| step_o | output | 1 | One-cycle strobe on each step |

## Verification
A corrupted phase index shows up at the very next step as a pattern that does not follow the expected forward or reverse order. An error in the interval counter or the active period changes the gap between two strobes, and that is visible within one step interval. A lost or early period update stretches or shortens the interval before the expected one. The bench therefore measures every gap between strobes and compares each pattern against a phase model it runs independently of the RTL.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
  localparam int unsigned PH_W  = 2;
  localparam int unsigned PAT_W = 4;

  function automatic logic [PAT_W-1:0] phase_pattern(input logic [PH_W-1:0] idx);
    case (idx)
      2'd0:    phase_pattern = 4'b0101;
      2'd1:    phase_pattern = 4'b1001;
      2'd2:    phase_pattern = 4'b1010;
      default: phase_pattern = 4'b0110;
    endcase
  endfunction
endpackage

// File: rtl/stepseq_prescaler.sv
module stepseq_prescaler #(
  parameter int unsigned DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] div_q;

  assign tick_o = (div_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (tick_o) div_q <= '0;
    else             div_q <= div_q + 1'b1;
  end

  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/stepseq_timer.sv
module stepseq_timer #(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned P_MIN = 50,
  parameter int unsigned P_MAX = 50000,
  parameter int unsigned P_RST = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             step_o
);
  localparam logic [CNT_W-1:0] MIN_V = CNT_W'(P_MIN);
  localparam logic [CNT_W-1:0] MAX_V = CNT_W'(P_MAX);
  localparam logic [CNT_W-1:0] RST_V = CNT_W'(P_RST);

  logic [CNT_W-1:0] cnt_q, per_q, stage_q, wr_clamped;
  logic             pend_q;

  always_comb begin
    if (wr_data_i < MIN_V)      wr_clamped = MIN_V;
    else if (wr_data_i > MAX_V) wr_clamped = MAX_V;
    else                        wr_clamped = wr_data_i;
  end

  // match on the tick that would bring the count up to the period
  assign step_o = tick_i && (({1'b0, cnt_q} + 1'b1) == {1'b0, per_q});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      per_q   <= RST_V;
      stage_q <= RST_V;
      pend_q  <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= step_o ? '0 : cnt_q + 1'b1;
      if (step_o && pend_q) per_q <= stage_q;
      if (wr_en_i) begin
        stage_q <= wr_clamped;
        pend_q  <= 1'b1;
      end else if (step_o) begin
        pend_q  <= 1'b0;
      end
    end
  end

  a_r7_period_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= MIN_V);
  a_r8_period_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q <= MAX_V);
  a_r9_write_pends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> pend_q);
  a_r6_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && pend_q && !wr_en_i) |=> (!pend_q && per_q == $past(stage_q)));
  a_r6_hold_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_o |=> $stable(per_q));
endmodule

// File: rtl/stepseq_phase.sv
module stepseq_phase
  import stepseq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             dir_i,
  output logic [PAT_W-1:0] pattern_o,
  output logic             step_o
);
  logic [PH_W-1:0]  phase_q, phase_d;
  logic [PAT_W-1:0] pat_q;
  logic             stb_q;

  assign phase_d = dir_i ? phase_q + 1'b1 : phase_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      pat_q   <= phase_pattern('0);
      stb_q   <= 1'b0;
    end else begin
      stb_q <= step_i;
      if (step_i) begin
        phase_q <= phase_d;
        pat_q   <= phase_pattern(phase_d);
      end
    end
  end

  assign pattern_o = pat_q;
  assign step_o    = stb_q;

  a_r4_dir_fwd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && dir_i) |=> (phase_q == $past(phase_q) + 2'd1));
  a_r4_dir_rev: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !dir_i) |=> (phase_q == $past(phase_q) - 2'd1));
  a_r10_pattern_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pat_q));
  a_r3_two_coils: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pat_q) == 2);
endmodule

// File: rtl/stepper_phase_gen.sv
module stepper_phase_gen
  import stepseq_pkg::*;
#(
  parameter int unsigned PRESC_DIV = 2,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned P_MIN     = 50,
  parameter int unsigned P_MAX     = 50000,
  parameter int unsigned P_RST     = 50
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dir_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [PAT_W-1:0] pattern_o,
  output logic             step_o
);
  logic tick, step_evt;

  stepseq_prescaler #(.DIV(PRESC_DIV)) i_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  stepseq_timer #(
    .CNT_W (CNT_W),
    .P_MIN (P_MIN),
    .P_MAX (P_MAX),
    .P_RST (P_RST)
  ) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .step_o    (step_evt)
  );

  stepseq_phase i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step_evt),
    .dir_i     (dir_i),
    .pattern_o (pattern_o),
    .step_o    (step_o)
  );

  a_r5_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);
  a_r5_step_needs_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_evt |-> tick);
endmodule

// File: tb/test_stepper_phase_gen.sv
module test_stepper_phase_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pattern;
  logic        step;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_cyc = 0;
  int cur_p = 50;
  int ph = 0;

  // {dir, written value}
  localparam logic [16:0] VEC [6] = '{
    {1'b1, 16'd60}, {1'b1, 16'd75}, {1'b0, 16'd10},
    {1'b0, 16'd120}, {1'b1, 16'd50}, {1'b0, 16'd49}
  };

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stepper_phase_gen i_stepper_phase_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dir_i     (dir),
    .wr_en_i   (wr_en),
    .wr_data_i (wr_data),
    .pattern_o (pattern),
    .step_o    (step)
  );

  function automatic logic [3:0] exp_pat(input int p);
    case (p & 3)
      0: exp_pat = 4'b0101;
      1: exp_pat = 4'b1001;
      2: exp_pat = 4'b1010;
      default: exp_pat = 4'b0110;
    endcase
  endfunction

  function automatic int clampv(input int v);
    if (v < 50) return 50;
    if (v > 50000) return 50000;
    return v;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_step(output int gap);
    do @(negedge clk); while (!step);
    gap = cyc - last_cyc;
    last_cyc = cyc;
  endtask

  task automatic step_seen(input bit d, input string req);
    ph = d ? ph + 1 : ph - 1;
    check(pattern == exp_pat(ph), req, pattern, exp_pat(ph));
  endtask

  task automatic write_now(input int v);
    wr_en = 1'b1; wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check(pattern == 4'b0101, "R1", pattern, 4'b0101);
    check(step == 1'b0, "R1", step, 0);
    @(negedge clk);
    rst_n = 1'b1;
    last_cyc = cyc;
    ph = 0;
    cur_p = 50;
  endtask

  initial begin
    #(190000 * 8);
    check(1'b0, "watchdog", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int gap;
    logic [3:0] held;
    repeat (3) @(negedge clk);
    do_reset();
    wait_step(gap);
    check(gap == 100, "R1", gap, 100);
    step_seen(1'b1, "R3");

    // table walk: new value held off for one interval, then applied
    for (int i = 0; i < 6; i++) begin
      dir = VEC[i][16];
      held = pattern;
      write_now(int'(VEC[i][15:0]));
      check(step == 1'b0, "R5", step, 0);
      check(pattern == held, "R10", pattern, held);
      wait_step(gap);
      check(gap == 2 * cur_p, "R6", gap, 2 * cur_p);
      step_seen(dir, "R4");
      cur_p = clampv(int'(VEC[i][15:0]));
      wait_step(gap);
      check(gap == 2 * cur_p, (VEC[i][15:0] < 50) ? "R7" : "R2", gap, 2 * cur_p);
      step_seen(dir, "R3");
    end

    // write on the step edge, with another value already pending
    dir = 1'b1;
    write_now(64);
    repeat (2 * cur_p - 2) @(negedge clk);
    wr_en = 1'b1; wr_data = 16'd90;
    @(negedge clk);
    wr_en = 1'b0;
    check(step == 1'b1, "R9", step, 1);
    check(cyc - last_cyc == 2 * cur_p, "R9", cyc - last_cyc, 2 * cur_p);
    last_cyc = cyc;
    step_seen(1'b1, "R5");
    wait_step(gap);
    check(gap == 128, "R9", gap, 128);
    step_seen(1'b1, "R4");
    wait_step(gap);
    check(gap == 180, "R9", gap, 180);
    step_seen(1'b1, "R4");

    // reset during a run restores the defaults
    repeat (7) @(negedge clk);
    do_reset();
    wait_step(gap);
    check(gap == 100, "R1", gap, 100);
    step_seen(1'b1, "R3");

    // upper clamp
    write_now(60000);
    wait_step(gap);
    check(gap == 100, "R6", gap, 100);
    step_seen(1'b1, "R4");
    write_now(50);
    wait_step(gap);
    check(gap == 100000, "R8", gap, 100000);
    step_seen(1'b1, "R3");
    wait_step(gap);
    check(gap == 100, "R2", gap, 100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule